// File: doc/BRIEF.md
# Segment Access Checker

The block decides whether one memory reference may use a segment whose descriptor is already loaded. Each request supplies the descriptor fields, the offset within the segment, the kind of reference and the privilege level of the running code. One clock later the block answers with one of two results. It either gives the 32-bit linear address, which is the segment base plus the offset, or it flags a fault and gives a cause code that says which rule failed.

The block checks presence, privilege, the access type against the segment type and read/write attributes, and the offset against the limit. The limit can be counted in bytes or in 4 KB pages. For a segment that grows downward, the limit is the floor of the valid range rather than its ceiling. The checker has no state other than its response register, so a new request can be issued on every cycle.

Top module: `seg_access_check`

## Requirements
- R1: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R2: A request that breaks no rule responds with `rsp_fault`=0, `rsp_cause`=0 and `rsp_lin_addr` = (`seg_base` + `acc_offset`) mod 2^32.
- R3: A request that breaks a rule responds with `rsp_fault`=1, a `rsp_cause` between 1 and 4, and `rsp_lin_addr`=0.
- R4: The effective limit depends on `seg_gran`. When it is 0, the effective limit is `seg_limit` in bytes. When it is 1, the effective limit is `seg_limit`*4096 + 4095.
- R5: For a segment that grows upward (`seg_expdown`=0), an offset greater than the effective limit gives cause 4 (limit). An offset equal to the effective limit is allowed.
- R6: For `seg_expdown`=1, an offset is valid only if it is strictly greater than the effective limit and no greater than the top. The top is 0xFFFF when `seg_big`=0 and 0xFFFFFFFF when `seg_big`=1. Any other offset gives cause 4.
- R7: `seg_present`=0 gives cause 1 (absent), whatever else is wrong with the request.
- R8: The privilege rule depends on the segment. For a conforming code segment (`seg_code`=1 and `seg_conforming`=1), the request passes when `seg_dpl` <= `cur_pl`. For every other segment it passes when `cur_pl` <= `seg_dpl`. A failure gives cause 2, which takes priority over causes 3 and 4.
- R9: The type rule depends on the access kind. A read needs `seg_readable`=1. A write needs `seg_code`=0 and `seg_writable`=1. An execute needs `seg_code`=1. A failure gives cause 3, which takes priority over cause 4.
- R10: `acc_kind` is encoded as 0 read, 1 write, 2 execute. The value 3 is reserved and always fails the type rule (cause 3).
- R11: In the cycle after a cycle with no request, `rsp_fault`, `rsp_cause` and `rsp_lin_addr` keep their previous values.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| acc_offset | input | 32 | Offset within the segment |
| cur_pl | input | 2 | Privilege level of the running code (0 is most privileged) |
| seg_base | input | 32 | Segment base address |
| seg_limit | input | 20 | Raw segment limit |
| seg_gran | input | 1 | Limit unit: 0 bytes, 1 4 KB pages |
| seg_big | input | 1 | Default size: 0 16-bit, 1 32-bit (sets the top of a downward segment) |
| seg_expdown | input | 1 | Segment grows downward |
| seg_present | input | 1 | Segment is present |
| seg_code | input | 1 | 1 code segment, 0 data segment |
| seg_conforming | input | 1 | Code segment adopts the caller's privilege |
| seg_readable | input | 1 | Reads permitted |
| seg_writable | input | 1 | Writes permitted (data segments only) |
| seg_dpl | input | 2 | Descriptor privilege level |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_fault | output | 1 | Request refused |
| rsp_cause | output | 3 | 0 none, 1 absent, 2 privilege, 3 type, 4 limit |
| rsp_lin_addr | output | 32 | Linear address when there is no fault, else 0 |

## Verification
The hardest cases to reach are the edges of a downward segment with page granularity. An offset exactly one above the scaled limit, or exactly at the 16-bit top or one past it, hardly ever comes from random offsets. Directed requests hit each of these edges, and the equal-to-limit edge of an upward segment, under both `seg_big` settings. Priority ordering is checked by requests that break two or three rules at once, so that only the highest-ranked cause may appear. A random sweep with narrow limits and frequent attribute changes covers the remaining combinations against the bench's reference model.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_ABSENT = 3'd1,
    CAUSE_PRIV   = 3'd2,
    CAUSE_TYPE   = 3'd3,
    CAUSE_LIMIT  = 3'd4
  } cause_e;

  typedef struct packed {
    logic present;
    logic code;
    logic conforming;
    logic readable;
    logic writable;
    logic expdown;
    logic gran;
    logic big;
  } seg_flags_t;

endpackage

// File: rtl/seg_limit_unit.sv
module seg_limit_unit #(
  parameter int ADDR_W      = 32,
  parameter int LIMIT_W     = 20,
  parameter int PAGE_SHIFT  = 12,
  parameter int SMALL_TOP_W = 16
) (
  input  logic [LIMIT_W-1:0] raw_limit,
  input  logic               gran,
  input  logic               big,
  input  logic               expdown,
  input  logic [ADDR_W-1:0]  offset,
  output logic               in_bounds
);

  localparam int SCALED_W = LIMIT_W + PAGE_SHIFT;

  logic [ADDR_W-1:0] lim_bytes;
  logic [ADDR_W-1:0] lim_pages;
  logic [ADDR_W-1:0] lim_eff;
  logic [ADDR_W-1:0] top_small;
  logic [ADDR_W-1:0] top_eff;
  logic              up_ok;
  logic              down_ok;

  assign lim_bytes = {{(ADDR_W-LIMIT_W){1'b0}}, raw_limit};

  generate
    if (SCALED_W < ADDR_W) begin : g_pad_scaled
      assign lim_pages = {{(ADDR_W-SCALED_W){1'b0}}, raw_limit, {PAGE_SHIFT{1'b1}}};
    end else begin : g_full_scaled
      assign lim_pages = {raw_limit, {PAGE_SHIFT{1'b1}}};
    end
    if (SMALL_TOP_W < ADDR_W) begin : g_pad_top
      assign top_small = {{(ADDR_W-SMALL_TOP_W){1'b0}}, {SMALL_TOP_W{1'b1}}};
    end else begin : g_full_top
      assign top_small = {ADDR_W{1'b1}};
    end
  endgenerate

  always_comb begin
    lim_eff = gran ? lim_pages : lim_bytes;
    top_eff = big ? {ADDR_W{1'b1}} : top_small;
    up_ok   = (offset <= lim_eff);
    down_ok = (offset > lim_eff) && (offset <= top_eff);
    in_bounds = expdown ? down_ok : up_ok;
  end

endmodule

// File: rtl/seg_perm_unit.sv
module seg_perm_unit
  import seg_chk_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  seg_flags_t        flags,
  input  logic [PL_W-1:0]   dpl,
  input  logic [PL_W-1:0]   cpl,
  input  acc_kind_e         kind,
  output logic              priv_ok,
  output logic              type_ok
);

  logic adopts_caller;

  always_comb begin
    adopts_caller = flags.code && flags.conforming;
    priv_ok = adopts_caller ? (dpl <= cpl) : (cpl <= dpl);
  end

  always_comb begin
    unique case (kind)
      ACC_READ:  type_ok = flags.readable;
      ACC_WRITE: type_ok = !flags.code && flags.writable;
      ACC_EXEC:  type_ok = flags.code;
      default:   type_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/seg_fault_encode.sv
module seg_fault_encode
  import seg_chk_pkg::*;
(
  input  logic   present,
  input  logic   priv_ok,
  input  logic   type_ok,
  input  logic   in_bounds,
  output cause_e cause
);

  always_comb begin
    if (!present)       cause = CAUSE_ABSENT;
    else if (!priv_ok)  cause = CAUSE_PRIV;
    else if (!type_ok)  cause = CAUSE_TYPE;
    else if (!in_bounds) cause = CAUSE_LIMIT;
    else                cause = CAUSE_NONE;
  end

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LIMIT_W     = 20,
  parameter int PAGE_SHIFT  = 12,
  parameter int SMALL_TOP_W = 16,
  parameter int PL_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         acc_kind,
  input  logic [ADDR_W-1:0]  acc_offset,
  input  logic [PL_W-1:0]    cur_pl,
  input  logic [ADDR_W-1:0]  seg_base,
  input  logic [LIMIT_W-1:0] seg_limit,
  input  logic               seg_gran,
  input  logic               seg_big,
  input  logic               seg_expdown,
  input  logic               seg_present,
  input  logic               seg_code,
  input  logic               seg_conforming,
  input  logic               seg_readable,
  input  logic               seg_writable,
  input  logic [PL_W-1:0]    seg_dpl,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [2:0]         rsp_cause,
  output logic [ADDR_W-1:0]  rsp_lin_addr
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  seg_flags_t flags;
  acc_kind_e  kind;
  logic       in_bounds;
  logic       priv_ok;
  logic       type_ok;
  cause_e     cause;

  always_comb begin
    flags.present    = seg_present;
    flags.code       = seg_code;
    flags.conforming = seg_conforming;
    flags.readable   = seg_readable;
    flags.writable   = seg_writable;
    flags.expdown    = seg_expdown;
    flags.gran       = seg_gran;
    flags.big        = seg_big;
    kind             = acc_kind_e'(acc_kind);
  end

  seg_limit_unit #(
    .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W),
    .PAGE_SHIFT(PAGE_SHIFT), .SMALL_TOP_W(SMALL_TOP_W)
  ) u_limit (
    .raw_limit (seg_limit),
    .gran      (flags.gran),
    .big       (flags.big),
    .expdown   (flags.expdown),
    .offset    (acc_offset),
    .in_bounds (in_bounds)
  );

  seg_perm_unit #(.PL_W(PL_W)) u_perm (
    .flags   (flags),
    .dpl     (seg_dpl),
    .cpl     (cur_pl),
    .kind    (kind),
    .priv_ok (priv_ok),
    .type_ok (type_ok)
  );

  seg_fault_encode u_enc (
    .present   (flags.present),
    .priv_ok   (priv_ok),
    .type_ok   (type_ok),
    .in_bounds (in_bounds),
    .cause     (cause)
  );

  // Next-state logic
  logic              nxt_fault;
  logic [2:0]        nxt_cause;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] sum_addr;

  always_comb begin
    sum_addr  = seg_base + acc_offset;
    nxt_fault = (cause != CAUSE_NONE);
    nxt_cause = cause;
    nxt_addr  = nxt_fault ? '0 : sum_addr;
  end

  // Response registers; data registers enabled by the request strobe
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rsp_valid <= 1'b0;
    else             rsp_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_fault    <= 1'b0;
      rsp_cause    <= '0;
      rsp_lin_addr <= '0;
    end else if (req_valid) begin
      rsp_fault    <= nxt_fault;
      rsp_cause    <= nxt_cause;
      rsp_lin_addr <= nxt_addr;
    end
  end

endmodule

// File: rtl/seg_access_check_sva.sv
module seg_access_check_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              seg_present,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [2:0]        rsp_cause,
  input logic [ADDR_W-1:0] rsp_lin_addr
);

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_rsp_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_fault_matches_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));

  p_cause_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cause <= 3'd4);

  p_fault_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_lin_addr == '0));

  p_absent_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !seg_present) |=> (rsp_cause == 3'd1));

  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_cause) && $stable(rsp_fault) && $stable(rsp_lin_addr)));

endmodule

bind seg_access_check seg_access_check_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .req_valid    (req_valid),
  .seg_present  (seg_present),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_cause    (rsp_cause),
  .rsp_lin_addr (rsp_lin_addr)
);

// File: tb/tb_seg_access_check.sv
module tb_seg_access_check;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  acc_kind;
  logic [31:0] acc_offset;
  logic [1:0]  cur_pl;
  logic [31:0] seg_base;
  logic [19:0] seg_limit;
  logic        seg_gran, seg_big, seg_expdown, seg_present, seg_code;
  logic        seg_conforming, seg_readable, seg_writable;
  logic [1:0]  seg_dpl;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_cause;
  logic [31:0] rsp_lin_addr;

  seg_access_check dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
    .acc_offset(acc_offset), .cur_pl(cur_pl), .seg_base(seg_base),
    .seg_limit(seg_limit), .seg_gran(seg_gran), .seg_big(seg_big),
    .seg_expdown(seg_expdown), .seg_present(seg_present), .seg_code(seg_code),
    .seg_conforming(seg_conforming), .seg_readable(seg_readable),
    .seg_writable(seg_writable), .seg_dpl(seg_dpl), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_lin_addr(rsp_lin_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Expected response for the coming cycle
  bit          exp_valid = 0;
  bit          exp_fault = 0;
  int          exp_cause = 0;
  longint      exp_addr  = 0;
  string       exp_tag   = "R12";

  function automatic int ref_cause(int kind, longint off, int cpl, longint lim,
                                   bit g, bit b, bit ed, bit p, bit c, bit cf,
                                   bit r, bit w, int dpl);
    longint eff;
    longint top;
    bit priv, typ, fits;
    eff = g ? (lim * 4096 + 4095) : lim;
    top = b ? 64'h0000_0000_FFFF_FFFF : 64'h0000_0000_0000_FFFF;
    if (c && cf) priv = (dpl <= cpl);
    else         priv = (cpl <= dpl);
    case (kind)
      0: typ = r;
      1: typ = !c && w;
      2: typ = c;
      default: typ = 0;
    endcase
    if (ed) fits = (off > eff) && (off <= top);
    else    fits = (off <= eff);
    if (!p)         return 1;
    else if (!priv) return 2;
    else if (!typ)  return 3;
    else if (!fits) return 4;
    return 0;
  endfunction

  task automatic check_now();
    total++;
    if (rsp_valid !== exp_valid || rsp_fault !== exp_fault ||
        int'(rsp_cause) != exp_cause || rsp_lin_addr !== exp_addr[31:0]) begin
      bad++;
      $display("FAIL %s: got valid=%0d fault=%0d cause=%0d addr=%08h exp valid=%0d fault=%0d cause=%0d addr=%08h",
               exp_tag, rsp_valid, rsp_fault, rsp_cause, rsp_lin_addr,
               exp_valid, exp_fault, exp_cause, exp_addr[31:0]);
    end
  endtask

  // Check the response to the previous cycle, then drive the next request
  task automatic send(bit rq, int kind, longint off, int cpl, longint base,
                      longint lim, bit g, bit b, bit ed, bit p, bit c, bit cf,
                      bit r, bit w, int dpl, string tag);
    int cz;
    @(negedge clk);
    check_now();
    req_valid = rq; acc_kind = kind[1:0]; acc_offset = off[31:0];
    cur_pl = cpl[1:0]; seg_base = base[31:0]; seg_limit = lim[19:0];
    seg_gran = g; seg_big = b; seg_expdown = ed; seg_present = p;
    seg_code = c; seg_conforming = cf; seg_readable = r; seg_writable = w;
    seg_dpl = dpl[1:0];
    exp_valid = rq;
    if (rq) begin
      cz = ref_cause(kind, off, cpl, lim, g, b, ed, p, c, cf, r, w, dpl);
      exp_cause = cz;
      exp_fault = (cz != 0);
      exp_addr  = (cz != 0) ? 0 : ((base + off) & 64'hFFFF_FFFF);
      if (tag == "") begin
        case (cz)
          0: exp_tag = "R2";
          1: exp_tag = "R7";
          2: exp_tag = "R8";
          3: exp_tag = "R9";
          default: exp_tag = "R5";
        endcase
      end else exp_tag = tag;
    end else begin
      exp_tag = (tag == "") ? "R11" : tag;
    end
  endtask

  task automatic idle(string tag);
    send(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; acc_kind = 0; acc_offset = 0; cur_pl = 0;
    seg_base = 0; seg_limit = 0; seg_gran = 0; seg_big = 0; seg_expdown = 0;
    seg_present = 0; seg_code = 0; seg_conforming = 0; seg_readable = 0;
    seg_writable = 0; seg_dpl = 0;
    repeat (3) @(negedge clk);
    check_now();                      // R12: outputs cleared in reset
    rst_n = 1;
    for (int i = 0; i < 4; i++) idle("R12");

    // R2: plain read, write, execute inside limits
    send(1, 0, 32'h10, 0, 32'h1000, 20'hFF, 0,0,0,1,0,0,1,1, 3, "R2");
    send(1, 1, 32'hFF, 1, 32'hFFFF_FFF0, 20'hFF, 0,0,0,1,0,0,0,1, 2, "R2");
    send(1, 2, 32'h0, 0, 32'h400, 20'h0, 0,1,0,1,1,0,0,0, 0, "R2");
    // R1: gap then back-to-back
    idle("R1");
    idle("R11");
    // R5: upward limit edges
    send(1, 0, 32'h100, 0, 32'h0, 20'h100, 0,1,0,1,0,0,1,0, 0, "R5");
    send(1, 0, 32'h101, 0, 32'h0, 20'h100, 0,1,0,1,0,0,1,0, 0, "R5");
    // R4: page granularity
    send(1, 0, 32'h2FFF, 0, 32'h0, 20'h2, 1,1,0,1,0,0,1,0, 0, "R4");
    send(1, 0, 32'h3000, 0, 32'h0, 20'h2, 1,1,0,1,0,0,1,0, 0, "R4");
    send(1, 0, 32'hFFFF_FFFF, 0, 32'h5, 20'hFFFFF, 1,1,0,1,0,0,1,0, 0, "R4");
    // R6: downward segment edges, both sizes
    send(1, 1, 32'h10, 0, 32'h0, 20'h10, 0,0,1,1,0,0,0,1, 0, "R6");
    send(1, 1, 32'h11, 0, 32'h0, 20'h10, 0,0,1,1,0,0,0,1, 0, "R6");
    send(1, 1, 32'hFFFF, 0, 32'h0, 20'h10, 0,0,1,1,0,0,0,1, 0, "R6");
    send(1, 1, 32'h10000, 0, 32'h0, 20'h10, 0,0,1,1,0,0,0,1, 0, "R6");
    send(1, 1, 32'h10000, 0, 32'h0, 20'h10, 0,1,1,1,0,0,0,1, 0, "R6");
    send(1, 1, 32'hFFFF_FFFF, 0, 32'h0, 20'h10, 0,1,1,1,0,0,0,1, 0, "R6");
    send(1, 0, 32'h0FFF, 0, 32'h0, 20'h0, 1,0,1,1,0,0,1,0, 0, "R6");
    send(1, 0, 32'h1000, 0, 32'h0, 20'h0, 1,0,1,1,0,0,1,0, 0, "R6");
    // R7: absent beats every other fault
    send(1, 3, 32'hFFFF_FFFF, 3, 32'h0, 20'h0, 0,0,0,0,0,0,0,0, 0, "R7");
    // R8: privilege, normal and conforming
    send(1, 0, 32'h0, 3, 32'h0, 20'h0, 0,0,0,1,0,0,1,0, 2, "R8");
    send(1, 2, 32'h0, 3, 32'h0, 20'h0, 0,0,0,1,1,1,0,0, 1, "R8");
    send(1, 2, 32'h0, 0, 32'h0, 20'h0, 0,0,0,1,1,1,0,0, 1, "R8");
    send(1, 1, 32'h50, 1, 32'h0, 20'h0, 0,0,0,1,0,0,0,0, 0, "R8");
    // R9: type rules, ranked above limit
    send(1, 1, 32'h50, 0, 32'h0, 20'h0, 0,0,0,1,1,0,1,1, 0, "R9");
    send(1, 2, 32'h0, 0, 32'h0, 20'h0, 0,0,0,1,0,0,1,1, 0, "R9");
    send(1, 0, 32'h0, 0, 32'h0, 20'h0, 0,0,0,1,1,0,0,0, 0, "R9");
    // R10: reserved kind
    send(1, 3, 32'h0, 0, 32'h0, 20'hFFFFF, 1,1,0,1,1,0,1,1, 3, "R10");
    // R11: idle after a successful response holds it
    send(1, 0, 32'h44, 0, 32'h1234_0000, 20'hFFF, 0,0,0,1,0,0,1,0, 0, "R2");
    send(0, 3, 32'hFFFF_FFFF, 3, 32'h0, 20'h0, 0,0,0,0,0,0,0,0, 0, "R11");
    idle("R11");

    // Random sweep
    for (int n = 0; n < 4000; n++) begin
      bit rq;
      longint lim, off;
      bit g, ed;
      rq  = ($urandom_range(0, 7) != 0);
      g   = $urandom_range(0, 1);
      ed  = ($urandom_range(0, 3) == 0);
      lim = $urandom_range(0, 3) == 0 ? longint'($urandom) & 64'hFFFFF
                                      : longint'($urandom_range(0, 64));
      case ($urandom_range(0, 3))
        0: off = g ? lim * 4096 + 4095 + $urandom_range(0, 2) - 1 : lim + $urandom_range(0, 2) - 1;
        1: off = 64'h10000 - 1 + $urandom_range(0, 1);
        2: off = $urandom_range(0, 200);
        default: off = longint'($urandom);
      endcase
      if (off < 0) off = 0;
      off = off & 64'hFFFF_FFFF;
      send(rq, $urandom_range(0, 3), off, $urandom_range(0, 3),
           longint'($urandom), lim, g, $urandom_range(0, 1), ed,
           ($urandom_range(0, 7) != 0), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 3), "");
    end
    @(negedge clk);
    check_now();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule